// File: doc/BRIEF.md
# 100BASE-X Receive Start-of-Stream Detector

This block takes a descrambled 100BASE-X code-bit stream, one bit per accepted transfer, and turns it into nibble-wide receive signals: carrier sense, data valid, receive error and a 4-bit data nibble with a one-cycle strobe. Between frames it watches a 10-bit window that slides by one bit for every accepted code bit. It sorts each window into one of four cases: line idle, the opening of a start-of-stream delimiter, a false carrier, or harmless noise. When it finds a delimiter, it fixes the 5-bit symbol boundaries to it. It reports the delimiter as two data nibbles of value 5, then decodes each following 5B code group into a nibble until an end delimiter or line idle returns it to idle.

The input is a valid/ready stream. `bit_ready` is held high because the block never applies back-pressure. A code bit is consumed on every rising clock edge where `bit_valid` is high, and cycles with `bit_valid` low leave all internal state untouched. The output side is a plain receive interface with no back-pressure. Each nibble is presented for one cycle on `nib_stb`, and `rxd`/`rx_er` hold their last value between strobes.

Code groups are written first-received bit leftmost: idle I = 11111, J = 11000, K = 10001, T = 01101, R = 00111.

Top module: `rxs_sof_det`

## Requirements
- R1: A synchronous active-high `rst` drives `crs`, `rx_dv`, `rx_er` and `nib_stb` low and `rxd` to 0000 on the following edge. It also fills the window with ones.
- R2: While idle, the window advances by one bit per accepted bit, so a delimiter is found at any bit offset. Idle ones never raise `crs` or `rx_dv`.
- R3: When the window reads I then J (1111111000), the next five accepted bits are collected with `crs` still low. If the window then reads J then K (1100010001), `crs` and `rx_dv` rise together with a strobe carrying `rxd`=0101, and a second strobe with 0101 follows on the next clock.
- R4: After the delimiter, every five accepted bits form one symbol, decoded with this table (code to nibble): 11110=0, 01001=1, 10100=2, 10101=3, 01010=4, 01011=5, 01110=6, 01111=7, 10010=8, 10011=9, 10110=A, 10111=B, 11010=C, 11011=D, 11100=E, 11101=F. Each symbol is strobed with `rx_er` low when the symbol after it completes.
- R5: A received code group outside the R4 table is strobed with `rx_er` high and `rxd`=0000, and `rx_dv` stays high.
- R6: A symbol pair T,R or I,I during reception drops `crs` and `rx_dv` on the edge that takes the pair's last bit, and clears `rx_er` and `rxd`. Neither symbol of the pair is strobed.
- R7: While idle, a window with two zeros that are not adjacent (other than the I,J case of R3) starts a false carrier: `crs` and `rx_er` high, `rx_dv` low, `rxd`=1110.
- R8: If the five bits collected after I,J do not complete J,K, a false carrier as in R7 starts.
- R9: While idle, a window whose zeros are a single zero or one adjacent pair leaves every output unchanged.
- R10: A false carrier ends after ten accepted ones in a row have arrived after it began. `crs`, `rx_er` and `rxd` then return to low/0000.
- R11: `bit_ready` is always high, and cycles with `bit_valid` low do not advance the window or the symbol count.
- R12: `nib_stb` is high only while `rx_dv` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | A code bit is offered on `bit_data` |
| bit_data | input | 1 | Descrambled code bit |
| bit_ready | output | 1 | Always high: the block takes a bit on every valid cycle |
| crs | output | 1 | Carrier sense |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error / false carrier flag |
| rxd | output | 4 | Received nibble |
| nib_stb | output | 1 | One-cycle strobe marking a new nibble |

## Verification
The checker assumes that the reset is held for at least one edge before the input stream starts. It also assumes the stream reaching the block has already been descrambled, so the assertions on the false-carrier nibble and on the double 0101 strobe apply to whatever the line carries. The property that ties a rising `crs` to an accepted bit relies on `bit_valid` being sampled on the same edges as the design. To stay within these limits, the stimulus changes inputs only on falling edges, and every frame or noise burst starts from at least ten idle ones. It also sends frames with idle cycles inserted between bits, to show that symbol alignment survives gaps in `bit_valid`.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int SYM_W = 5;
  localparam int NIB_W = 4;
  localparam int WIN_W = 2 * SYM_W;

  localparam logic [SYM_W-1:0] CG_I = 5'b11111;
  localparam logic [SYM_W-1:0] CG_J = 5'b11000;
  localparam logic [SYM_W-1:0] CG_K = 5'b10001;
  localparam logic [SYM_W-1:0] CG_T = 5'b01101;
  localparam logic [SYM_W-1:0] CG_R = 5'b00111;

  localparam logic [NIB_W-1:0] NIB_SSD = 4'b0101;
  localparam logic [NIB_W-1:0] NIB_FC  = 4'b1110;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_RECV,
    ST_FALSE
  } rx_state_e;
endpackage

// File: rtl/rxs_window.sv
module rxs_window
  import rxs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             load_ones,
  input  logic             bit_in,
  output logic [WIN_W-1:0] win_nxt
);
  logic [WIN_W-1:0] win_q;

  // oldest bit at the top, newest bit enters at bit 0
  assign win_nxt = {win_q[WIN_W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst || load_ones) begin
      win_q <= '1;
    end else if (shift_en) begin
      win_q <= win_nxt;
    end
  end
endmodule

// File: rtl/rxs_classify.sv
module rxs_classify
  import rxs_pkg::*;
(
  input  logic [WIN_W-1:0] win,
  output logic             hit_pre,
  output logic             hit_ssd,
  output logic             hit_act,
  output logic             hit_end
);
  localparam logic [WIN_W-1:0] PAT_PRE = {CG_I, CG_J};
  localparam logic [WIN_W-1:0] PAT_SSD = {CG_J, CG_K};
  localparam logic [WIN_W-1:0] PAT_TR  = {CG_T, CG_R};
  localparam logic [WIN_W-1:0] PAT_II  = {CG_I, CG_I};

  assign hit_pre = (win == PAT_PRE);
  assign hit_ssd = (win == PAT_SSD);
  assign hit_end = (win == PAT_TR) || (win == PAT_II);

  // activity: some pair of zeros separated by at least one position
  always_comb begin
    hit_act = 1'b0;
    for (int a = 0; a < WIN_W; a++) begin
      for (int b = a + 2; b < WIN_W; b++) begin
        if (!win[a] && !win[b]) hit_act = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxs_dec5b.sv
module rxs_dec5b
  import rxs_pkg::*;
(
  input  logic [SYM_W-1:0] code,
  output logic [NIB_W-1:0] nib,
  output logic             ok
);
  always_comb begin
    ok  = 1'b1;
    nib = '0;
    unique case (code)
      5'b11110: nib = 4'h0;
      5'b01001: nib = 4'h1;
      5'b10100: nib = 4'h2;
      5'b10101: nib = 4'h3;
      5'b01010: nib = 4'h4;
      5'b01011: nib = 4'h5;
      5'b01110: nib = 4'h6;
      5'b01111: nib = 4'h7;
      5'b10010: nib = 4'h8;
      5'b10011: nib = 4'h9;
      5'b10110: nib = 4'hA;
      5'b10111: nib = 4'hB;
      5'b11010: nib = 4'hC;
      5'b11011: nib = 4'hD;
      5'b11100: nib = 4'hE;
      5'b11101: nib = 4'hF;
      default:  ok  = 1'b0;
    endcase
  end
endmodule

// File: rtl/rxs_sof_det.sv
module rxs_sof_det
  import rxs_pkg::*;
#(
  parameter int EXIT_ONES = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  input  logic             bit_data,
  output logic             bit_ready,
  output logic             crs,
  output logic             rx_dv,
  output logic             rx_er,
  output logic [NIB_W-1:0] rxd,
  output logic             nib_stb
);
  localparam int CNT_W = $clog2(SYM_W);
  localparam int RUN_W = $clog2(EXIT_ONES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYM_W - 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(EXIT_ONES - 1);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RUN_W-1:0] run_q;
  logic [SYM_W-1:0] hsym_q;
  logic             hvalid_q;
  logic             dup5_q;
  logic             crs_q, dv_q, er_q, stb_q;
  logic [NIB_W-1:0] rxd_q;

  logic [WIN_W-1:0] win_nxt;
  logic             hit_pre, hit_ssd, hit_act, hit_end;
  logic [NIB_W-1:0] dec_nib;
  logic             dec_ok;
  logic             sym_edge;
  logic             end_recv, end_false, go_idle;

  assign sym_edge  = bit_valid && (cnt_q == CNT_LAST);
  assign end_recv  = (state_q == ST_RECV) && sym_edge && hvalid_q && hit_end;
  assign end_false = (state_q == ST_FALSE) && bit_valid && bit_data && (run_q == RUN_LAST);
  assign go_idle   = end_recv || end_false;

  rxs_window u_win (
    .clk      (clk),
    .rst      (rst),
    .shift_en (bit_valid),
    .load_ones(go_idle),
    .bit_in   (bit_data),
    .win_nxt  (win_nxt)
  );

  rxs_classify u_cls (
    .win    (win_nxt),
    .hit_pre(hit_pre),
    .hit_ssd(hit_ssd),
    .hit_act(hit_act),
    .hit_end(hit_end)
  );

  rxs_dec5b u_dec (
    .code(hsym_q),
    .nib (dec_nib),
    .ok  (dec_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      run_q    <= '0;
      hsym_q   <= CG_I;
      hvalid_q <= 1'b0;
      dup5_q   <= 1'b0;
      crs_q    <= 1'b0;
      dv_q     <= 1'b0;
      er_q     <= 1'b0;
      stb_q    <= 1'b0;
      rxd_q    <= '0;
    end else begin
      stb_q <= 1'b0;
      if (dup5_q) begin
        stb_q  <= 1'b1;
        rxd_q  <= NIB_SSD;
        er_q   <= 1'b0;
        dup5_q <= 1'b0;
      end
      if (bit_valid) begin
        unique case (state_q)
          ST_IDLE: begin
            if (hit_pre) begin
              state_q <= ST_LOOK;
              cnt_q   <= '0;
            end else if (hit_act) begin
              state_q <= ST_FALSE;
              run_q   <= '0;
              crs_q   <= 1'b1;
              er_q    <= 1'b1;
              rxd_q   <= NIB_FC;
            end
          end
          ST_LOOK: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q <= '0;
              if (hit_ssd) begin
                state_q  <= ST_RECV;
                crs_q    <= 1'b1;
                dv_q     <= 1'b1;
                er_q     <= 1'b0;
                stb_q    <= 1'b1;
                rxd_q    <= NIB_SSD;
                dup5_q   <= 1'b1;
                hvalid_q <= 1'b0;
              end else begin
                state_q <= ST_FALSE;
                run_q   <= '0;
                crs_q   <= 1'b1;
                er_q    <= 1'b1;
                rxd_q   <= NIB_FC;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_RECV: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q <= '0;
              if (end_recv) begin
                state_q  <= ST_IDLE;
                hvalid_q <= 1'b0;
                crs_q    <= 1'b0;
                dv_q     <= 1'b0;
                er_q     <= 1'b0;
                rxd_q    <= '0;
              end else begin
                if (hvalid_q) begin
                  stb_q <= 1'b1;
                  rxd_q <= dec_ok ? dec_nib : '0;
                  er_q  <= !dec_ok;
                end
                hsym_q   <= win_nxt[SYM_W-1:0];
                hvalid_q <= 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_FALSE: begin
            if (end_false) begin
              state_q <= ST_IDLE;
              run_q   <= '0;
              crs_q   <= 1'b0;
              er_q    <= 1'b0;
              rxd_q   <= '0;
            end else if (bit_data) begin
              run_q <= run_q + 1'b1;
            end else begin
              run_q <= '0;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign bit_ready = 1'b1;
  assign crs       = crs_q;
  assign rx_dv     = dv_q;
  assign rx_er     = er_q;
  assign rxd       = rxd_q;
  assign nib_stb   = stb_q;
endmodule

// File: rtl/rxs_sof_chk.sv
module rxs_sof_chk (
  input logic       clk,
  input logic       rst,
  input logic       bit_valid,
  input logic       crs,
  input logic       rx_dv,
  input logic       rx_er,
  input logic [3:0] rxd,
  input logic       nib_stb
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!crs && !rx_dv && !rx_er && !nib_stb && rxd == 4'b0000));

  // R12
  stb_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    nib_stb |-> rx_dv);

  // R3
  dv_needs_crs_chk: assert property (@(posedge clk) disable iff (rst)
    rx_dv |-> crs);

  // R3
  ssd_first_nib_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_dv) |-> (nib_stb && rxd == 4'b0101 && !rx_er));

  // R3
  ssd_second_nib_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_dv) |=> (nib_stb && rxd == 4'b0101));

  // R7
  false_carrier_out_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_er && !rx_dv) |-> (crs && rxd == 4'b1110));

  // R10
  quiet_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    !crs |-> (!rx_er && rxd == 4'b0000));

  // R11
  crs_on_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(crs) |-> $past(bit_valid));
endmodule

bind rxs_sof_det rxs_sof_chk u_chk (.*);

// File: tb/sim_rxs_sof_det.sv
`timescale 1ns/1ps
module sim_rxs_sof_det;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_valid = 1'b0;
  logic       bit_data = 1'b1;
  logic       bit_ready;
  logic       crs, rx_dv, rx_er, nib_stb;
  logic [3:0] rxd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int cap_nib [64];
  int cap_er  [64];
  int cap_dv  [64];
  int cap_n = 0;
  bit crs_seen = 1'b0;

  localparam logic [4:0] S_I = 5'b11111, S_J = 5'b11000, S_K = 5'b10001;
  localparam logic [4:0] S_T = 5'b01101, S_R = 5'b00111;
  localparam logic [4:0] D_0 = 5'b11110, D_2 = 5'b10100, D_3 = 5'b10101;
  localparam logic [4:0] D_7 = 5'b01111, D_9 = 5'b10011, D_A = 5'b10110;
  localparam logic [4:0] D_F = 5'b11101;

  always #4 clk = ~clk;

  rxs_sof_det u0 (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_ready(bit_ready), .crs(crs), .rx_dv(rx_dv), .rx_er(rx_er),
    .rxd(rxd), .nib_stb(nib_stb)
  );

  always @(negedge clk) begin
    if (crs) crs_seen = 1'b1;
    if (nib_stb && cap_n < 64) begin
      cap_nib[cap_n] = int'(rxd);
      cap_er[cap_n]  = int'(rx_er);
      cap_dv[cap_n]  = int'(rx_dv);
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b, input int gap);
    @(negedge clk); bit_valid = 1'b1; bit_data = b;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk); bit_valid = 1'b0; bit_data = 1'b0;
    end
  endtask

  task automatic put_sym(input logic [4:0] s, input int gap);
    for (int i = 4; i >= 0; i--) put_bit(s[i], gap);
  endtask

  task automatic put_ones(input int n);
    for (int i = 0; i < n; i++) put_bit(1'b1, 0);
  endtask

  task automatic settle();
    @(negedge clk); bit_valid = 1'b0; bit_data = 1'b1;
  endtask

  task automatic clear_cap();
    cap_n = 0; crs_seen = 1'b0;
  endtask

  task automatic chk_cap(input int k, input int nib, input int er, input string req);
    chk(cap_n > k, req, cap_n, k + 1);
    if (cap_n > k) begin
      chk(cap_nib[k] == nib, req, cap_nib[k], nib);
      chk(cap_er[k] == er, req, cap_er[k], er);
      chk(cap_dv[k] == 1, "R12 strobe outside rx_dv", cap_dv[k], 1);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(crs == 0 && rx_dv == 0, "R1 crs/rx_dv in reset", int'({crs, rx_dv}), 0);
    chk(rx_er == 0 && nib_stb == 0, "R1 rx_er/nib_stb in reset", int'({rx_er, nib_stb}), 0);
    chk(rxd == 4'b0000, "R1 rxd in reset", int'(rxd), 0);
    chk(bit_ready == 1, "R11 bit_ready", int'(bit_ready), 1);
    rst = 1'b0;
  endtask

  task automatic t_idle_noise();
    clear_cap();
    put_ones(30);
    put_bit(1'b0, 0); put_ones(10);
    put_bit(1'b0, 0); put_bit(1'b0, 0); put_ones(12);
    settle();
    chk(crs_seen == 0, "R2 R9 crs during idle and noise", int'(crs_seen), 0);
    chk(cap_n == 0, "R9 no strobes from noise", cap_n, 0);
  endtask

  task automatic t_frame(input int lead, input int gap, input string tag);
    clear_cap();
    put_ones(lead);
    put_sym(S_J, gap);
    settle();
    chk(crs == 0, {tag, " R3 crs low while looking for K"}, int'(crs), 0);
    put_sym(S_K, gap);
    put_sym(D_3, gap); put_sym(D_A, gap); put_sym(D_0, gap); put_sym(D_F, gap);
    put_sym(S_T, gap);
    put_sym(S_R, 0);
    settle();
    chk(crs == 0 && rx_dv == 0, {tag, " R6 end on T,R"}, int'({crs, rx_dv}), 0);
    chk(cap_n == 6, {tag, " R4 nibble count"}, cap_n, 6);
    chk_cap(0, 5, 0, {tag, " R3 first delimiter nibble"});
    chk_cap(1, 5, 0, {tag, " R3 second delimiter nibble"});
    chk_cap(2, 3, 0, {tag, " R4 nibble 3"});
    chk_cap(3, 10, 0, {tag, " R4 nibble A"});
    chk_cap(4, 0, 0, {tag, " R4 nibble 0"});
    chk_cap(5, 15, 0, {tag, " R4 nibble F"});
    put_ones(12);
  endtask

  task automatic t_bad_code();
    clear_cap();
    put_ones(11);
    put_sym(S_J, 0); put_sym(S_K, 0);
    put_sym(D_7, 0); put_sym(5'b00000, 0); put_sym(D_2, 0);
    put_sym(S_T, 0); put_sym(S_R, 0);
    settle();
    chk(cap_n == 5, "R5 nibble count", cap_n, 5);
    chk_cap(2, 7, 0, "R5 nibble 7");
    chk_cap(3, 0, 1, "R5 invalid code flagged");
    chk_cap(4, 2, 0, "R5 nibble 2 after error");
    chk(crs == 0 && rx_er == 0 && rxd == 0, "R6 cleared after end", int'({crs, rx_er, rxd}), 0);
    put_ones(12);
  endtask

  task automatic t_idle_end();
    clear_cap();
    put_ones(14);
    put_sym(S_J, 0); put_sym(S_K, 0);
    put_sym(D_9, 0); put_sym(S_I, 0);
    put_bit(1'b1, 0); put_bit(1'b1, 0); put_bit(1'b1, 0); put_bit(1'b1, 0);
    settle();
    chk(rx_dv == 1, "R6 rx_dv held until last bit of I,I", int'(rx_dv), 1);
    put_bit(1'b1, 0);
    settle();
    chk(crs == 0 && rx_dv == 0, "R6 end on I,I", int'({crs, rx_dv}), 0);
    chk(cap_n == 3, "R6 idle pair not strobed", cap_n, 3);
    chk_cap(2, 9, 0, "R4 nibble 9");
    put_ones(12);
  endtask

  task automatic t_false_carrier();
    clear_cap();
    put_ones(12);
    put_bit(1'b0, 0); put_bit(1'b1, 0); put_bit(1'b0, 0);
    settle();
    chk(crs == 1 && rx_er == 1, "R7 crs/rx_er on false carrier", int'({crs, rx_er}), 3);
    chk(rx_dv == 0, "R7 rx_dv low on false carrier", int'(rx_dv), 0);
    chk(rxd == 4'b1110, "R7 rxd on false carrier", int'(rxd), 14);
    put_ones(9);
    settle();
    chk(crs == 1, "R10 still in false carrier after nine ones", int'(crs), 1);
    put_ones(1);
    settle();
    chk(crs == 0 && rx_er == 0 && rxd == 0, "R10 exit after ten ones", int'({crs, rx_er, rxd}), 0);
    chk(cap_n == 0, "R12 no strobes in false carrier", cap_n, 0);
  endtask

  task automatic t_bad_ssd();
    clear_cap();
    put_ones(10);
    put_sym(S_J, 0);
    put_sym(S_I, 0);
    settle();
    chk(crs == 1 && rx_er == 1 && rx_dv == 0, "R8 bad delimiter", int'({crs, rx_er, rx_dv}), 6);
    chk(rxd == 4'b1110, "R8 rxd on bad delimiter", int'(rxd), 14);
    put_ones(10);
    settle();
    chk(crs == 0, "R10 exit after bad delimiter", int'(crs), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle_noise();
    t_frame(12, 0, "aligned");
    t_frame(13, 0, "R2 shifted");
    t_frame(10, 2, "R11 gapped");
    t_bad_code();
    t_idle_end();
    t_false_carrier();
    t_bad_ssd();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule